// File: doc/BRIEF.md
# Command-Byte I2C Register Target

This block is a two-wire serial target that answers one fixed 7-bit bus address and fronts a small sensor register file. Both bus lines are oversampled by the system clock. A small bit engine finds start, repeated start and stop conditions, shifts bytes in on rising SCL and changes SDA only while SCL is low. SDA is driven as an open-drain pull-down.

After the address, the first byte of a write may be a command. A command sets the register pointer and the access type: stay on one register, step forward after every byte, or run a one-shot special function. The special functions emit single-cycle interrupt-clear pulses. Data bytes, and all read bytes, use the stored pointer, which survives across transactions. Each 16-bit result word is read low byte first. Reading the low byte latches the matching high byte into a shadow register, so the word stays coherent while conversions go on.

The bus FSM has these states. `ST_IDLE` waits for a start. `ST_ADDR` shifts in the address byte. `ST_ACK_A` drives the address acknowledge. `ST_RX` shifts in a write byte. `ST_ACK_R` acknowledges it. `ST_TX` shifts a read byte out. `ST_ACK_T` samples the controller's acknowledge. `ST_DROP` ignores the bus until the next start or stop.

The transitions are:
- A stop sends any state to `ST_IDLE`. A start or repeated start sends any state to `ST_ADDR`.
- From `ST_ADDR`, the SCL fall after the eighth bit goes to `ST_ACK_A` on an address match and to `ST_DROP` otherwise.
- From `ST_ACK_A`, the next fall goes to `ST_TX` for a read and to `ST_RX` for a write.
- From `ST_RX`, the fall after eight bits goes to `ST_ACK_R`, and the next fall returns to `ST_RX`.
- From `ST_TX`, the fall after eight bits goes to `ST_ACK_T`. From `ST_ACK_T`, the next fall goes to `ST_TX` on an acknowledge and to `ST_DROP` on a not-acknowledge.

Top module: `sensor_cmd_i2c`

## Requirements
- R1: Only bus address 0x39 is acknowledged. Any other address gets no acknowledge (SDA stays released in the ninth bit), and the rest of that transaction changes nothing.
- R2: In a write, the first byte after the address is a command when its bit 7 is 1. In a command, bits 6:5 give the type and bits 4:0 give the register pointer (or the special code).
- R3: Command type 00 (repeat) keeps the pointer fixed. Successive data writes all land on that one register, and successive reads return that register.
- R4: Command type 01 (step) moves the pointer up by one after every data byte written or read. Configuration registers 0x00 to 0x0F are writable and read back what was written. Configuration registers change only while the FSM is in `ST_RX`.
- R5: In step mode the pointer wraps from 0x1F to 0x00.
- R6: A read with no command reads at the stored pointer. A first write byte with bit 7 clear is data, stored at the stored pointer.
- R7: Command type 11 runs a special code. Code 00101 pulses `prox_clr_o`, code 00110 pulses `als_clr_o`, and code 00111 pulses both. Each pulse lasts exactly one clock. Every other code does nothing. A special command leaves the pointer and type unchanged.
- R8: Command type 10 is reserved. The whole byte is ignored, and later data bytes go to the previously stored pointer.
- R9: Reset values are 0xFF at 0x02 and 0x03 and 0x00 in the other configuration registers. 0x12 is a read-only identity byte (0x29). 0x13 reads `status_i` and is read-only. Addresses 0x10, 0x11 and 0x1A to 0x1F read 0x00 and ignore writes.
- R10: Result word k has its low byte at 0x14+2k and its high byte at 0x15+2k. Reading the low byte copies the live high byte into a shadow register. Reading the high byte returns that shadow copy, even if the input has changed since.
- R11: SDA changes only while SCL is low. A repeated start begins a new address phase without a stop in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| status_i | input | 8 | Live status byte shown at 0x13 |
| result_i | input | 48 | Three 16-bit result words, word k at bits 16k+15:16k |
| cfg_o | output | 128 | Configuration registers, register i at bits 8i+7:8i |
| prox_clr_o | output | 1 | One-clock proximity interrupt clear |
| als_clr_o | output | 1 | One-clock light interrupt clear |

## Verification
Two things can fall in the same clock: the shadow capture on a low-byte load, and a change on the result input. The bench provokes this by stepping result word 0 by 23 on every clock while it reads the word with auto-increment. It then requires the assembled word to be one value the input actually held during the read: a multiple of 23 away from the start value, and inside the window the read spanned. Without the shadow copy, the high byte would come from a value hundreds of clocks later, so the two halves would not match.

// File: rtl/sensor_cmd_pkg.sv
`timescale 1ns/1ps
package sensor_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_RX,
        ST_ACK_R,
        ST_TX,
        ST_ACK_T,
        ST_DROP
    } bus_st_e;

    typedef enum logic [1:0] {
        TY_REPEAT  = 2'b00,
        TY_STEP    = 2'b01,
        TY_RSVD    = 2'b10,
        TY_SPECIAL = 2'b11
    } cmd_ty_e;

    localparam logic [4:0] SF_CLR_PROX = 5'd5;
    localparam logic [4:0] SF_CLR_ALS  = 5'd6;
    localparam logic [4:0] SF_CLR_BOTH = 5'd7;

endpackage

// File: rtl/scmd_line_sync.sv
`timescale 1ns/1ps
module scmd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // STAGES flops for metastability, one more to hold the previous level
    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;
    logic            scl_p;
    logic            sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    always_comb begin
        scl_s     = scl_q[STAGES-1];
        sda_s     = sda_q[STAGES-1];
        scl_p     = scl_q[STAGES];
        sda_p     = sda_q[STAGES];
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_det = scl_s & scl_p & sda_p & ~sda_s;
        stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/scmd_regfile.sv
`timescale 1ns/1ps
module scmd_regfile #(
    parameter int          AW         = 5,
    parameter int          N_CFG      = 16,
    parameter int          N_RES      = 3,
    parameter int          RES_BASE   = 20,
    parameter int          ID_ADDR    = 18,
    parameter int          STAT_ADDR  = 19,
    parameter int          PTIME_ADDR = 2,
    parameter int          WTIME_ADDR = 3,
    parameter logic [7:0]  DEV_ID     = 8'h29
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 rd_take,
    input  logic [AW-1:0]        rd_addr,
    output logic [7:0]           rd_data,
    input  logic [7:0]           status_i,
    input  logic [N_RES*16-1:0]  result_i,
    output logic [N_CFG*8-1:0]   cfg_o
);
    logic [7:0] cfg_q [N_CFG];
    logic [7:0] shd_q [N_RES];

    for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
        localparam logic [7:0] RV = (g == PTIME_ADDR || g == WTIME_ADDR) ? 8'hFF : 8'h00;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= RV;
            end else if (wr_en && wr_addr == AW'(g)) begin
                cfg_q[g] <= wr_data;
            end
        end
        assign cfg_o[g*8 +: 8] = cfg_q[g];
    end

    // high byte is frozen when its low byte is handed to the bus
    for (genvar k = 0; k < N_RES; k++) begin : g_shd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shd_q[k] <= 8'h00;
            end else if (rd_take && rd_addr == AW'(RES_BASE + 2*k)) begin
                shd_q[k] <= result_i[k*16+8 +: 8];
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < N_CFG; i++) begin
            if (rd_addr == AW'(i)) rd_data = cfg_q[i];
        end
        for (int k = 0; k < N_RES; k++) begin
            if (rd_addr == AW'(RES_BASE + 2*k))     rd_data = result_i[k*16 +: 8];
            if (rd_addr == AW'(RES_BASE + 2*k + 1)) rd_data = shd_q[k];
        end
        if (rd_addr == AW'(ID_ADDR))   rd_data = DEV_ID;
        if (rd_addr == AW'(STAT_ADDR)) rd_data = status_i;
    end

endmodule

// File: rtl/sensor_cmd_i2c.sv
`timescale 1ns/1ps
module sensor_cmd_i2c
    import sensor_cmd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h39,
    parameter logic [7:0] DEV_ID      = 8'h29,
    parameter int         N_CFG       = 16,
    parameter int         N_RES       = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic [7:0]          status_i,
    input  logic [N_RES*16-1:0] result_i,
    output logic [N_CFG*8-1:0]  cfg_o,
    output logic                prox_clr_o,
    output logic                als_clr_o
);
    localparam int AW         = 5;
    localparam int ID_ADDR    = 18;
    localparam int STAT_ADDR  = 19;
    localparam int RES_BASE   = 20;
    localparam int PTIME_ADDR = 2;
    localparam int WTIME_ADDR = 3;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    bus_st_e       state_q, state_n;
    logic [3:0]    bit_cnt_q;
    logic [7:0]    sh_q;
    logic [7:0]    tx_q;
    logic          rd_dir_q;
    logic          first_q;
    logic          nack_q;
    logic [AW-1:0] addr_q;
    logic          step_q;
    logic          prox_clr_q, als_clr_q;

    logic          byte_end, is_cmd, wr_en, rd_take;
    logic [7:0]    rd_data;
    cmd_ty_e       cmd_ty;

    scmd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    always_comb begin
        byte_end = scl_fall && (bit_cnt_q == 4'd8);
        is_cmd   = first_q && sh_q[7];
        cmd_ty   = cmd_ty_e'(sh_q[6:5]);
        wr_en    = (state_q == ST_RX) && byte_end && !is_cmd;
        rd_take  = scl_fall && (((state_q == ST_ACK_A) && rd_dir_q) ||
                                ((state_q == ST_ACK_T) && !nack_q));
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_n = ST_IDLE;
                ST_ADDR:  if (byte_end) state_n = (sh_q[7:1] == DEV_ADDR) ? ST_ACK_A : ST_DROP;
                ST_ACK_A: if (scl_fall) state_n = rd_dir_q ? ST_TX : ST_RX;
                ST_RX:    if (byte_end) state_n = ST_ACK_R;
                ST_ACK_R: if (scl_fall) state_n = ST_RX;
                ST_TX:    if (byte_end) state_n = ST_ACK_T;
                ST_ACK_T: if (scl_fall) state_n = nack_q ? ST_DROP : ST_TX;
                ST_DROP:  state_n = ST_DROP;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // byte shifting, command decode and pointer handling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= 4'd0;
            sh_q       <= 8'h00;
            tx_q       <= 8'hFF;
            rd_dir_q   <= 1'b0;
            first_q    <= 1'b0;
            nack_q     <= 1'b0;
            addr_q     <= '0;
            step_q     <= 1'b0;
            prox_clr_q <= 1'b0;
            als_clr_q  <= 1'b0;
        end else begin
            prox_clr_q <= 1'b0;
            als_clr_q  <= 1'b0;
            if (start_det) begin
                bit_cnt_q <= 4'd0;
                first_q   <= 1'b1;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            sh_q      <= {sh_q[6:0], sda_s};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end
                        if (byte_end) begin
                            bit_cnt_q <= 4'd0;
                            if (state_q == ST_ADDR) begin
                                rd_dir_q <= sh_q[0];
                            end else begin
                                first_q <= 1'b0;
                                if (is_cmd) begin
                                    unique case (cmd_ty)
                                        TY_REPEAT: begin addr_q <= sh_q[4:0]; step_q <= 1'b0; end
                                        TY_STEP:   begin addr_q <= sh_q[4:0]; step_q <= 1'b1; end
                                        TY_SPECIAL: begin
                                            prox_clr_q <= (sh_q[4:0] == SF_CLR_PROX) || (sh_q[4:0] == SF_CLR_BOTH);
                                            als_clr_q  <= (sh_q[4:0] == SF_CLR_ALS)  || (sh_q[4:0] == SF_CLR_BOTH);
                                        end
                                        default: ;
                                    endcase
                                end else if (step_q) begin
                                    addr_q <= addr_q + 1'b1;
                                end
                            end
                        end
                    end
                    ST_ACK_A, ST_ACK_T: begin
                        if (scl_rise) nack_q <= sda_s;
                        if (rd_take) begin
                            tx_q <= rd_data;
                            if (step_q) addr_q <= addr_q + 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bit_cnt_q <= bit_cnt_q + 4'd1;
                        if (scl_fall) begin
                            if (bit_cnt_q == 4'd8) bit_cnt_q <= 4'd0;
                            else                   tx_q <= {tx_q[6:0], 1'b1};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o   = (state_q == ST_ACK_A) || (state_q == ST_ACK_R) ||
                     ((state_q == ST_TX) && !tx_q[7]);
        prox_clr_o = prox_clr_q;
        als_clr_o  = als_clr_q;
    end

    scmd_regfile #(
        .AW         (AW),
        .N_CFG      (N_CFG),
        .N_RES      (N_RES),
        .RES_BASE   (RES_BASE),
        .ID_ADDR    (ID_ADDR),
        .STAT_ADDR  (STAT_ADDR),
        .PTIME_ADDR (PTIME_ADDR),
        .WTIME_ADDR (WTIME_ADDR),
        .DEV_ID     (DEV_ID)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (addr_q),
        .wr_data  (sh_q),
        .rd_take  (rd_take),
        .rd_addr  (addr_q),
        .rd_data  (rd_data),
        .status_i (status_i),
        .result_i (result_i),
        .cfg_o    (cfg_o)
    );

endmodule

// File: rtl/sensor_cmd_i2c_chk.sv
`timescale 1ns/1ps
module sensor_cmd_i2c_chk
    import sensor_cmd_pkg::*;
#(
    parameter int N_CFG      = 16,
    parameter int PTIME_ADDR = 2,
    parameter int WTIME_ADDR = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic               scl_fall,
    input logic               sda_oe,
    input logic               prox_clr,
    input logic               als_clr,
    input bus_st_e            state,
    input logic [N_CFG*8-1:0] cfg
);

    // R11: data line is held while the synchronised clock stays high
    p_sda_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R7: special-function pulses last one clock
    p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prox_clr || als_clr) |=> !(prox_clr || als_clr));

    // R7: pulses follow a completed byte
    p_clr_after_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prox_clr || als_clr) |-> $past(scl_fall));

    // R4: configuration changes only out of a write byte
    p_cfg_write_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> ($past(state) == ST_RX));

    // R9: timing registers leave reset at all ones
    p_reset_vals_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg[PTIME_ADDR*8 +: 8] == 8'hFF && cfg[WTIME_ADDR*8 +: 8] == 8'hFF));

endmodule

bind sensor_cmd_i2c sensor_cmd_i2c_chk #(
    .N_CFG      (N_CFG),
    .PTIME_ADDR (PTIME_ADDR),
    .WTIME_ADDR (WTIME_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .scl_fall (scl_fall),
    .sda_oe   (sda_oe_o),
    .prox_clr (prox_clr_o),
    .als_clr  (als_clr_o),
    .state    (state_q),
    .cfg      (cfg_o)
);

// File: tb/sensor_cmd_i2c_tb.sv
`timescale 1ns/1ps
module sensor_cmd_i2c_tb;
    localparam int Q = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_oe;
    logic [7:0]   status = 8'h00;
    logic [15:0]  res0 = 16'h0, res1 = 16'h0, res2 = 16'h0;
    logic [47:0]  result;
    logic [127:0] cfg;
    logic         prox_clr, als_clr;
    logic         sda_line;

    int n_chk = 0, n_bad = 0, n_prox = 0, n_als = 0;
    int ctr = 0;
    logic run_ctr = 1'b0, done = 1'b0;
    logic [7:0] mdl [16];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign result   = {res2, res1, run_ctr ? ctr[15:0] : res0};

    sensor_cmd_i2c u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .status_i(status), .result_i(result), .cfg_o(cfg),
        .prox_clr_o(prox_clr), .als_clr_o(als_clr)
    );

    always @(negedge clk) begin
        if (prox_clr) n_prox++;
        if (als_clr)  n_als++;
        if (run_ctr)  ctr += 23;
    end

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic chk_cfg(string tag);
        logic [127:0] e;
        for (int i = 0; i < 16; i++) e[i*8 +: 8] = mdl[i];
        n_chk++;
        if (cfg !== e) begin
            n_bad++;
            $display("FAIL %s cfg got %h exp %h", tag, cfg, e);
        end
    endtask

    task automatic bit_io(input logic b, output logic r);
        sda_m = b;  tick(Q);
        scl_m = 1'b1; tick(Q);
        r = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic b_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic b_rstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic b_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(b[i], r);
        bit_io(1'b1, r);
        ack = ~r;
    endtask

    task automatic rbyte(input logic last, output logic [7:0] d);
        logic r;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, r);
            d = {d[6:0], r};
        end
        bit_io(last, r);
    endtask

    task automatic send(input logic [7:0] b);
        logic a;
        wbyte(b, a);
    endtask

    // start, address for write, one command, stop
    task automatic do_cmd(input logic [7:0] c);
        b_start(); send(8'h72); send(c); b_stop();
    endtask

    // command then repeated start and a single byte read
    task automatic cmd_read1(input logic [7:0] c, output logic [7:0] d);
        b_start(); send(8'h72); send(c); b_rstart(); send(8'h73); rbyte(1'b1, d); b_stop();
    endtask

    task automatic plain_read1(output logic [7:0] d);
        b_start(); send(8'h73); rbyte(1'b1, d); b_stop();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        logic       a;
        logic [7:0] d, lo, hi;
        int         p0, p1, bef, aft, w;
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        mdl[2] = 8'hFF; mdl[3] = 8'hFF;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R9 reset state at the ports
        chk_cfg("R9 reset values");
        chk("R9 sda released", 16'(sda_oe), 16'h0);
        chk("R7 no pulse at reset", 16'(prox_clr | als_clr), 16'h0);

        // R1 address filter: flipped-bit neighbours are refused, rest ignored
        for (int b = 0; b < 7; b++) begin
            b_start();
            wbyte({7'h39 ^ 7'(1 << b), 1'b0}, a);
            chk("R1 foreign address nack", 16'(a), 16'h0);
            send(8'h80); send(8'hAA); b_stop();
            chk_cfg("R1 foreign transfer ignored");
        end
        b_start(); wbyte(8'h72, a); b_stop();
        chk("R1 own address ack", 16'(a), 16'h1);

        // R2 R4 step-mode write sweep over every configuration register
        b_start(); send(8'h72); send(8'hA0);
        for (int i = 0; i < 16; i++) begin
            send(pat(i));
            mdl[i] = pat(i);
            tick(2);
            chk_cfg("R4 step write");
        end
        b_stop();
        // R4 R11 read back through a repeated start
        b_start(); send(8'h72); send(8'hA0); b_rstart(); send(8'h73);
        for (int i = 0; i < 16; i++) begin
            rbyte(i == 15, d);
            chk("R4 R11 step read", 16'(d), 16'(pat(i)));
        end
        b_stop();

        // R5 wrap from 0x1F to 0x00
        b_start(); send(8'h72); send(8'hBE); b_rstart(); send(8'h73);
        rbyte(1'b0, d); chk("R5 read 0x1E", 16'(d), 16'h0);
        rbyte(1'b0, d); chk("R5 read 0x1F", 16'(d), 16'h0);
        rbyte(1'b1, d); chk("R5 wrapped to 0x00", 16'(d), 16'(pat(0)));
        b_stop();

        // R6 no command: pointer now 0x01 in step mode
        plain_read1(d); chk("R6 read at stored pointer", 16'(d), 16'(pat(1)));
        b_start(); send(8'h72); send(8'h5A); b_stop();
        mdl[2] = 8'h5A;
        chk_cfg("R6 data-first write at stored pointer");
        plain_read1(d); chk("R6 pointer stepped after write", 16'(d), 16'(pat(3)));

        // R3 repeat mode
        b_start(); send(8'h72); send(8'h85); send(8'h11); send(8'h22); send(8'h33); b_stop();
        mdl[5] = 8'h33;
        chk_cfg("R3 repeat write stays on one register");
        b_start(); send(8'h72); send(8'h87); b_rstart(); send(8'h73);
        for (int i = 0; i < 3; i++) begin
            rbyte(i == 2, d);
            chk("R3 repeat read", 16'(d), 16'(pat(7)));
        end
        b_stop();

        // R8 reserved type ignored, data goes to previous pointer 0x07
        b_start(); send(8'h72); send(8'hC9); send(8'h44); b_stop();
        mdl[7] = 8'h44;
        chk_cfg("R8 reserved command ignored");
        plain_read1(d); chk("R8 pointer kept", 16'(d), 16'h44);

        // R9 read-only and reserved addresses
        cmd_read1(8'h92, d); chk("R9 identity", 16'(d), 16'h29);
        b_start(); send(8'h72); send(8'h92); send(8'h55); b_stop();
        plain_read1(d); chk("R9 identity write ignored", 16'(d), 16'h29);
        chk_cfg("R9 identity write leaves config");
        b_start(); send(8'h72); send(8'h90); send(8'h77); b_stop();
        plain_read1(d); chk("R9 reserved 0x10 reads zero", 16'(d), 16'h0);
        status = 8'hC3;
        cmd_read1(8'h93, d); chk("R9 status byte", 16'(d), 16'hC3);
        cmd_read1(8'h9A, d); chk("R9 reserved 0x1A reads zero", 16'(d), 16'h0);
        chk_cfg("R9 config after read-only writes");

        // R7 sweep of every special code, pointer parked at 0x04 repeat
        do_cmd(8'h84);
        for (int c = 0; c < 32; c++) begin
            p0 = n_prox; p1 = n_als;
            do_cmd(8'hE0 | 8'(c));
            chk("R7 proximity clear cycles", 16'(n_prox - p0), 16'((c == 5 || c == 7) ? 1 : 0));
            chk("R7 light clear cycles", 16'(n_als - p1), 16'((c == 6 || c == 7) ? 1 : 0));
        end
        b_start(); send(8'h73); rbyte(1'b0, d);
        chk("R7 pointer kept after specials", 16'(d), 16'(pat(4)));
        rbyte(1'b1, d);
        chk("R7 repeat type kept after specials", 16'(d), 16'(pat(4)));
        b_stop();
        chk_cfg("R7 specials leave config");

        // R10 word layout and shadow
        res0 = 16'hE5F6; res1 = 16'hC3D4; res2 = 16'hA1B2;
        for (int k = 0; k < 3; k++) begin
            b_start(); send(8'h72); send(8'hA0 | 8'(20 + 2*k)); b_rstart(); send(8'h73);
            rbyte(1'b0, lo); rbyte(1'b1, hi); b_stop();
            chk("R10 word low first", 16'(lo), 16'(result[k*16 +: 8]));
            chk("R10 word high second", 16'(hi), 16'(result[k*16+8 +: 8]));
        end
        res1 = 16'h1357;
        cmd_read1(8'h96, d); chk("R10 low byte", 16'(d), 16'h57);
        res1 = 16'h2468;
        cmd_read1(8'h97, d); chk("R10 high from shadow", 16'(d), 16'h13);
        cmd_read1(8'h96, d); chk("R10 low byte live", 16'(d), 16'h68);
        cmd_read1(8'h97, d); chk("R10 shadow refreshed", 16'(d), 16'h24);

        // R10 input stepping every clock during a word read
        ctr = 256;
        run_ctr = 1'b1;
        bef = ctr;
        b_start(); send(8'h72); send(8'hB4); b_rstart(); send(8'h73);
        rbyte(1'b0, lo); rbyte(1'b1, hi); b_stop();
        aft = ctr;
        run_ctr = 1'b0;
        w = int'({hi, lo});
        chk("R10 coherent word on grid", 16'((w - 256) % 23), 16'h0);
        chk("R10 coherent word in window", 16'(w >= bef && w <= aft), 16'h1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired got running exp finished");
            summary();
            $finish;
        end
    end

endmodule